// File: doc/BRIEF.md
# Delayed Windowed-Eventually Runtime Monitor

This block watches a stream of quantized samples and decides, for each sample time t, whether a threshold condition on the sample becomes true at least once somewhere between a steps and b steps after t (0 ≤ a ≤ b). The condition compares the digitized sample against a threshold word, either as strictly-below or as below-or-equal. The monitor advances by one time step only on cycles where the sample strobe is high. Idle cycles do not count as time.

A future-looking condition cannot be decided when its sample arrives. The monitor therefore answers the question b steps late. When sample k = t + b arrives, the verdict for time t is the OR of the condition over samples k−(b−a) through k. This window is held in a short shift register of condition bits. A saturating warm-up counter keeps the verdict strobe low until the first complete window exists. A synchronous clear returns the monitor to its just-reset state.

Top module: `stl_window_monitor`

## Requirements
- R1: The per-sample condition is an unsigned comparison of `smp_data` with `thresh`. With `cmp_le` = 0 it is `smp_data < thresh`. With `cmp_le` = 1 it is `smp_data <= thresh`.
- R2: A sample is accepted on a rising clock edge where `smp_vld` = 1 and `sync_clr` = 0. `verdict_vld` is high in the cycle after an accepted sample, and only then, provided at least WIN_HI samples were accepted before it since reset or clear.
- R3: The first WIN_HI accepted samples after reset or clear raise no `verdict_vld`.
- R4: When `verdict_vld` is high for accepted sample k, `verdict` is 1 exactly when the condition held for at least one of the accepted samples k−(WIN_HI−WIN_LO) through k.
- R5: Cycles without an accepted sample do not advance time. They raise no `verdict_vld` and do not change the condition history, so idle gaps leave later verdicts unchanged.
- R6: A cycle with `sync_clr` = 1 clears the condition history, the warm-up count, `verdict` and `verdict_vld`. Conditions seen before the clear never reach a later verdict.
- R7: While `rst_n` is low, `verdict` and `verdict_vld` are 0.
- R8: `verdict` keeps its last value on every cycle that follows no accepted sample and no clear.
- R9: When `sync_clr` and `smp_vld` are high together, the clear wins and the sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with clk |
| sync_clr | input | 1 | Synchronous clear of history and warm-up |
| smp_vld | input | 1 | Sample strobe; one time step per high cycle |
| smp_data | input | SAMPLE_W | Quantized converter sample |
| thresh | input | SAMPLE_W | Threshold word |
| cmp_le | input | 1 | 0: strictly below, 1: below or equal |
| verdict | output | 1 | Property result for time k−WIN_HI |
| verdict_vld | output | 1 | One-cycle strobe marking a new verdict |

## Verification
The hardest case to reach from the ports is the window edge. A lone true condition must be reported by exactly WIN_HI−WIN_LO+1 consecutive verdicts. Idle gaps and clears must neither stretch nor shorten that run. To isolate each comparison, the stimulus feeds each swept sample after WIN_HI−WIN_LO samples whose condition is known to be false, so that verdict equals that one sample's condition. Random phases then put idle gaps, clears and clear-with-sample cycles at arbitrary points inside the warm-up and inside live windows.

// File: rtl/stl_mon_pkg.sv
package stl_mon_pkg;

  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_LE = 1'b1
  } cmp_mode_e;

endpackage

// File: rtl/mon_pred.sv
module mon_pred
  import stl_mon_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] x,
  input  logic [SAMPLE_W-1:0] u,
  input  cmp_mode_e           mode,
  output logic                hit
);

  logic below;
  logic equal;

  always_comb begin
    below = (x < u);
    equal = (x == u);
    unique case (mode)
      CMP_LT:  hit = below;
      CMP_LE:  hit = below | equal;
      default: hit = below;
    endcase
  end

endmodule

// File: rtl/mon_history.sv
module mon_history #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             bit_in,
  output logic [DEPTH-1:0] win
);

  generate
    if (DEPTH > 1) begin : g_shift
      logic [DEPTH-2:0] hist_q;
      logic [DEPTH-2:0] hist_d;

      assign win = {hist_q, bit_in};

      always_comb begin
        hist_d = hist_q;
        if (clr) begin
          hist_d = '0;
        end else if (adv) begin
          hist_d = win[DEPTH-2:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
        end else begin
          hist_q <= hist_d;
        end
      end
    end else begin : g_single
      assign win = bit_in;
    end
  endgenerate

endmodule

// File: rtl/mon_warmup.sv
module mon_warmup #(
  parameter int HORIZON = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic full
);

  generate
    if (HORIZON > 0) begin : g_count
      localparam int CW = $clog2(HORIZON + 1);
      localparam logic [CW-1:0] LIMIT = CW'(HORIZON);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      assign full = (cnt_q == LIMIT);

      always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
          cnt_d = '0;
        end else if (adv && !full) begin
          cnt_d = cnt_q + CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end
    end else begin : g_none
      assign full = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/stl_window_monitor.sv
module stl_window_monitor
  import stl_mon_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WIN_LO   = 2,
  parameter int WIN_HI   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                cmp_le,
  output logic                verdict,
  output logic                verdict_vld
);

  localparam int DEPTH = WIN_HI - WIN_LO + 1;

  logic             adv;
  logic             hit;
  logic             full;
  logic [DEPTH-1:0] win;
  logic             verd_q, verd_d;
  logic             vld_q, vld_d;
  cmp_mode_e        mode;

  // clear takes precedence over a simultaneous sample
  assign adv  = smp_vld & ~sync_clr;
  assign mode = cmp_mode_e'(cmp_le);

  mon_pred #(.SAMPLE_W(SAMPLE_W)) u_pred (
    .x    (smp_data),
    .u    (thresh),
    .mode (mode),
    .hit  (hit)
  );

  mon_history #(.DEPTH(DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sync_clr),
    .adv    (adv),
    .bit_in (hit),
    .win    (win)
  );

  mon_warmup #(.HORIZON(WIN_HI)) u_warm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .adv   (adv),
    .full  (full)
  );

  always_comb begin
    verd_d = verd_q;
    vld_d  = 1'b0;
    if (sync_clr) begin
      verd_d = 1'b0;
    end else if (adv) begin
      verd_d = |win;
      vld_d  = full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      verd_q <= verd_d;
      vld_q  <= vld_d;
    end
  end

  assign verdict     = verd_q;
  assign verdict_vld = vld_q;

endmodule

// File: rtl/stl_window_monitor_chk.sv
module stl_window_monitor_chk #(
  parameter int WIN_HI = 5
) (
  input logic clk,
  input logic rst_n,
  input logic sync_clr,
  input logic smp_vld,
  input logic verdict,
  input logic verdict_vld
);

  localparam int CW = $clog2(WIN_HI + 2);
  localparam logic [CW-1:0] LIM = CW'(WIN_HI);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (sync_clr) begin
      seen_q <= '0;
    end else if (smp_vld && seen_q != LIM) begin
      seen_q <= seen_q + CW'(1);
    end
  end

  AST_VLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(smp_vld && !sync_clr)); // R2

  AST_WARMUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !sync_clr) |=> (verdict_vld == $past(seen_q == LIM))); // R3

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (!verdict_vld && !verdict)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !sync_clr) |=> ($stable(verdict) && !verdict_vld)); // R8

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!verdict && !verdict_vld)); // R7

endmodule

bind stl_window_monitor stl_window_monitor_chk #(.WIN_HI(WIN_HI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_clr    (sync_clr),
  .smp_vld     (smp_vld),
  .verdict     (verdict),
  .verdict_vld (verdict_vld)
);

// File: tb/stl_window_monitor_test.sv
`timescale 1ns/1ps
module stl_window_monitor_test;

  localparam int W     = 8;
  localparam int LO    = 2;
  localparam int HI    = 5;
  localparam int DEPTH = HI - LO + 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sync_clr;
  logic         smp_vld;
  logic [W-1:0] smp_data;
  logic [W-1:0] thresh;
  logic         cmp_le;
  logic         verdict;
  logic         verdict_vld;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [DEPTH-1:0] mhist;
  int               mcnt;
  logic             exp_verd;

  always #10 clk = ~clk;

  stl_window_monitor #(.SAMPLE_W(W), .WIN_LO(LO), .WIN_HI(HI)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_clr    (sync_clr),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .thresh      (thresh),
    .cmp_le      (cmp_le),
    .verdict     (verdict),
    .verdict_vld (verdict_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cond(input logic [W-1:0] x, input logic [W-1:0] u, input logic m);
    return m ? (x <= u) : (x < u);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic send(input logic [W-1:0] x, input logic [W-1:0] u, input logic m,
                      input string req);
    logic exp_v;
    smp_data = x;
    thresh   = u;
    cmp_le   = m;
    smp_vld  = 1'b1;
    exp_v    = (mcnt >= HI);
    mhist    = {mhist[DEPTH-2:0], cond(x, u, m)};
    exp_verd = |mhist;
    if (mcnt < HI) mcnt++;
    @(negedge clk);
    smp_vld = 1'b0;
    check(verdict_vld == exp_v, {req, " vld"}, verdict_vld, exp_v);
    check(verdict == exp_verd, {req, " verdict"}, verdict, exp_verd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(verdict_vld == 1'b0, "R5 idle vld", verdict_vld, 0);
      check(verdict == exp_verd, "R8 idle hold", verdict, exp_verd);
    end
  endtask

  task automatic clear(input logic with_sample);
    sync_clr = 1'b1;
    smp_vld  = with_sample;
    smp_data = 8'd0;
    thresh   = 8'd255;
    cmp_le   = 1'b1;
    mhist    = '0;
    mcnt     = 0;
    exp_verd = 1'b0;
    @(negedge clk);
    sync_clr = 1'b0;
    smp_vld  = 1'b0;
    check(verdict_vld == 1'b0, with_sample ? "R9 clr+smp vld" : "R6 clr vld", verdict_vld, 0);
    check(verdict == 1'b0, with_sample ? "R9 clr+smp verdict" : "R6 clr verdict", verdict, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_clr = 1'b0; smp_vld = 1'b0;
    smp_data = '0; thresh = '0; cmp_le = 1'b0;
    mhist = '0; mcnt = 0; exp_verd = 1'b0;
    repeat (3) @(negedge clk);
    check(verdict == 1'b0, "R7 reset verdict", verdict, 0);
    check(verdict_vld == 1'b0, "R7 reset vld", verdict_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: warm-up, all conditions true, no strobe for HI samples
    for (int i = 0; i < HI + 3; i++) send(8'd1, 8'd9, 1'b0, "R3 warmup");

    // R4: a lone true condition is reported by exactly DEPTH verdicts
    for (int i = 0; i < DEPTH; i++) send(8'd255, 8'd0, 1'b0, "R4 flush");
    send(8'd3, 8'd4, 1'b0, "R4 single");
    for (int i = 0; i < DEPTH + 2; i++) send(8'd255, 8'd0, 1'b0, "R4 tail");

    // R5: the same lone true with idle gaps inside the window
    send(8'd7, 8'd7, 1'b1, "R5 single");
    for (int i = 0; i < DEPTH + 1; i++) begin
      idle(i + 1);
      send(8'd200, 8'd100, 1'b1, "R5 gapped");
    end

    // R1: comparison sweep, each test sample isolated behind false ones
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 256; x += 5)
        for (int u = 0; u < 256; u += 7) begin
          for (int k = 0; k < DEPTH - 1; k++) send(8'd255, 8'd0, 1'b0, "R1 pad");
          send(x[W-1:0], u[W-1:0], m[0], "R1 compare");
        end
    // R1 equality boundary at both ends of the range
    for (int k = 0; k < DEPTH - 1; k++) send(8'd255, 8'd0, 1'b0, "R1 pad");
    send(8'd0, 8'd0, 1'b1, "R1 le zero");
    for (int k = 0; k < DEPTH - 1; k++) send(8'd255, 8'd0, 1'b0, "R1 pad");
    send(8'd255, 8'd255, 1'b0, "R1 lt max");

    // R6: clear, then old conditions must not leak; warm-up restarts
    for (int i = 0; i < 3; i++) send(8'd0, 8'd1, 1'b0, "R6 pre");
    clear(1'b0);
    for (int i = 0; i < HI + DEPTH; i++) send(8'd255, 8'd0, 1'b0, "R6 after");

    // R9: clear with a true sample present; sample is dropped
    clear(1'b1);
    for (int i = 0; i < HI + DEPTH; i++) send(8'd255, 8'd0, 1'b0, "R9 after");

    // R2 R4 R5 R6 R8: random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) clear(r[0]);
      else if (r < 15) idle($urandom_range(1, 3));
      else send(W'($urandom_range(0, 255)), W'($urandom_range(0, 255)),
                1'($urandom_range(0, 1)), "R2 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule